// File: doc/BRIEF.md
# Register-Mapped Byte-Exchange SPI Master

This block is an SPI bus master that sits behind a 32-bit word register port with two registers: a control/status word and a data word. Software first places an outgoing byte in the data word, then writes the control word with its go bit set. The block clocks that byte out on the serial output, most significant bit first. At the same time it gathers one byte from the serial input. When the exchange ends, the gathered byte becomes readable from the data word.

The control word holds three chip-select outputs and a loopback switch. Loopback feeds the serial output straight back to the receive path. The word also holds a serial-clock divider. Clock polarity and phase are fixed at build time by parameters. Each control write carries all fields at once. Control writes are taken only while no exchange is running.

Top module: `spi_master_regs`

## Requirements
- R1: The register port uses word addresses. Address 0 selects the control/status word and address 1 selects the data word. A read of address 2 or 3 returns zero, and the read data is valid in the same cycle as the read request.
- R2: After reset, the control word reads 0x00000015 and the data word reads 0. All three chip selects are high and the serial clock is low.
- R3: Chip selects 0, 1 and 2 take the values of control bits 0, 2 and 4 on the clock edge that accepts a control write, whether or not the go bit is set. They then hold those values while an exchange runs.
- R4: A control write with bit 1 set, made while idle, starts an exchange. Control bit 1 then reads as a busy flag, high from the cycle after that write until the exchange ends. The written go bit is never stored, so bit 1 reads 0 once idle.
- R5: With divider D taken from control bits 31:27, the serial clock toggles every D+1 clock cycles, with the first toggle D+1 cycles after the go write. In the default mode (idle low, sample on the rising edge) it toggles 15 times. On the cycle after the eighth rising edge, busy goes low and the serial clock returns low.
- R6: The serial output shows bit 7 of the data word from the start of the exchange. It moves to the next lower bit after each falling serial-clock edge. A receiver sampling on rising edges therefore collects the written byte.
- R7: The serial input is sampled on each rising serial-clock edge, most significant bit first. After the exchange, the data word reads that byte in bits 7:0, with bits 31:8 zero.
- R8: While control bit 3 is set, the received byte equals the transmitted byte, whatever the serial input does.
- R9: A control write made while busy is ignored completely. The exchange is not restarted, and chip selects, divider and loopback keep their values.
- R10: Control bits 31:27 read back the divider and control bit 3 reads back the loopback setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Register access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, same cycle |
| sck_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| cs_o | output | 3 | Chip-select lines |

## Verification
The exchange is tried with several byte pairs:
- 0x3C against 0xA5 at the fastest divider.
- 0x81 against 0x7E at divider 3.
- 0xFF against 0x00 at the largest divider.

Opposite and alternating bit patterns show up bit-order or off-by-one shift mistakes in both directions. The three dividers separate errors in half-period length from errors in edge count. In the loopback run, the input pin carries a byte different from the one sent, so any leak from the pin shows up. In one run a full control word arrives mid-exchange, and the run shows whether that write restarts the exchange, moves the chip selects or switches on loopback.

// File: rtl/spim_pkg.sv
`timescale 1ns/1ps
package spim_pkg;
  localparam int REG_W = 32;
  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_DATA = 2'd1;
  localparam int BIT_GO   = 1;
  localparam int BIT_LOOP = 3;

  // bit position of chip-select line i inside the control word
  function automatic int cs_pos(input int i);
    return 2 * i;
  endfunction

  // zero-based index of the serial-clock edge that takes the final sample
  function automatic int last_sample_edge(input int nbits, input bit cpha);
    return 2 * nbits - (cpha ? 1 : 2);
  endfunction

  // even indices are leading edges; phase 0 samples on leading, phase 1 on trailing
  function automatic bit is_sample_edge(input int idx, input bit cpha);
    return ((idx % 2) == 1) == cpha;
  endfunction
endpackage

// File: rtl/spim_baud.sv
`timescale 1ns/1ps
module spim_baud #(
  parameter int DIV_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q;

  assign tick = run && (cnt_q == div);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!run || tick) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/spim_shift.sv
`timescale 1ns/1ps
module spim_shift
  import spim_pkg::*;
#(
  parameter int XFER_BITS = 8,
  parameter bit CPOL      = 1'b0,
  parameter bit CPHA      = 1'b0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [XFER_BITS-1:0] tx_byte,
  input  logic                 tick,
  input  logic                 loop_en,
  input  logic                 miso,
  output logic                 sck,
  output logic                 mosi,
  output logic                 fin,
  output logic [XFER_BITS-1:0] rx_bits
);
  localparam int EC_W = $clog2(2 * XFER_BITS + 1);
  localparam int LAST = last_sample_edge(XFER_BITS, CPHA);

  logic [EC_W-1:0]      edge_q;
  logic [XFER_BITS-1:0] tx_q;
  logic [XFER_BITS-1:0] rx_q;
  logic                 sck_q;
  logic                 fin_q;
  logic                 samp_now;
  logic                 shift_now;
  logic                 rx_in;

  assign mosi      = tx_q[XFER_BITS-1];
  assign rx_in     = loop_en ? mosi : miso;
  assign samp_now  = tick && is_sample_edge(int'(edge_q), CPHA);
  assign shift_now = tick && !is_sample_edge(int'(edge_q), CPHA)
                     && !(CPHA && (edge_q == '0));
  assign sck       = sck_q;
  assign fin       = fin_q;
  assign rx_bits   = rx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      edge_q <= '0;
      tx_q   <= '0;
      rx_q   <= '0;
      sck_q  <= CPOL;
      fin_q  <= 1'b0;
    end else if (start) begin
      edge_q <= '0;
      tx_q   <= tx_byte;
      rx_q   <= '0;
      sck_q  <= CPOL;
      fin_q  <= 1'b0;
    end else if (fin_q) begin
      fin_q <= 1'b0;
      sck_q <= CPOL;
    end else if (tick) begin
      sck_q  <= ~sck_q;
      edge_q <= edge_q + 1'b1;
      if (samp_now) begin
        rx_q <= {rx_q[XFER_BITS-2:0], rx_in};
      end
      if (shift_now) begin
        tx_q <= {tx_q[XFER_BITS-2:0], 1'b0};
      end
      if (int'(edge_q) == LAST) begin
        fin_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/spim_regs.sv
`timescale 1ns/1ps
module spim_regs
  import spim_pkg::*;
#(
  parameter int NUM_CS    = 3,
  parameter int DIV_W     = 5,
  parameter int XFER_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_valid,
  input  logic                 bus_we,
  input  logic [1:0]           bus_addr,
  input  logic [REG_W-1:0]     bus_wdata,
  output logic [REG_W-1:0]     bus_rdata,
  input  logic                 done,
  input  logic [XFER_BITS-1:0] rx_bits,
  output logic                 start,
  output logic                 start_req,
  output logic                 busy,
  output logic                 loop_en,
  output logic [DIV_W-1:0]     div,
  output logic [NUM_CS-1:0]    cs,
  output logic [XFER_BITS-1:0] tx_byte
);
  localparam int DIV_LSB = REG_W - DIV_W;

  logic                 ctrl_wr;
  logic                 ctrl_take;
  logic                 data_wr;
  logic                 busy_q;
  logic                 loop_q;
  logic [DIV_W-1:0]     div_q;
  logic [NUM_CS-1:0]    cs_q;
  logic [NUM_CS-1:0]    cs_wr;
  logic [XFER_BITS-1:0] tx_q;
  logic [XFER_BITS-1:0] rx_q;
  logic                 unused_wdata;

  assign ctrl_wr   = bus_valid && bus_we && (bus_addr == A_CTRL);
  assign data_wr   = bus_valid && bus_we && (bus_addr == A_DATA);
  assign ctrl_take = ctrl_wr && !busy_q;
  assign start_req = ctrl_wr && bus_wdata[BIT_GO];
  assign start     = ctrl_take && bus_wdata[BIT_GO];
  assign unused_wdata = ^bus_wdata;

  for (genvar i = 0; i < NUM_CS; i++) begin : g_cs_field
    assign cs_wr[i] = bus_wdata[cs_pos(i)];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      loop_q <= 1'b0;
      div_q  <= '0;
      cs_q   <= '1;
      tx_q   <= '0;
      rx_q   <= '0;
    end else begin
      if (ctrl_take) begin
        cs_q   <= cs_wr;
        loop_q <= bus_wdata[BIT_LOOP];
        div_q  <= bus_wdata[DIV_LSB +: DIV_W];
      end
      if (data_wr) begin
        tx_q <= bus_wdata[XFER_BITS-1:0];
      end
      if (start) begin
        busy_q <= 1'b1;
      end else if (done) begin
        busy_q <= 1'b0;
      end
      if (done) begin
        rx_q <= rx_bits;
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_valid && !bus_we) begin
      if (bus_addr == A_CTRL) begin
        bus_rdata[DIV_LSB +: DIV_W] = div_q;
        bus_rdata[BIT_LOOP]         = loop_q;
        bus_rdata[BIT_GO]           = busy_q;
        for (int i = 0; i < NUM_CS; i++) begin
          bus_rdata[cs_pos(i)] = cs_q[i];
        end
      end else if (bus_addr == A_DATA) begin
        bus_rdata[XFER_BITS-1:0] = rx_q;
      end
    end
  end

  assign busy    = busy_q;
  assign loop_en = loop_q;
  assign div     = div_q;
  assign cs      = cs_q;
  assign tx_byte = tx_q;
endmodule

// File: rtl/spi_master_regs.sv
`timescale 1ns/1ps
module spi_master_regs
  import spim_pkg::*;
#(
  parameter int XFER_BITS = 8,
  parameter int NUM_CS    = 3,
  parameter int DIV_W     = 5,
  parameter bit CPOL      = 1'b0,
  parameter bit CPHA      = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_we,
  input  logic [1:0]        bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              sck_o,
  output logic              mosi_o,
  input  logic              miso_i,
  output logic [NUM_CS-1:0] cs_o
);
  logic                 start_w;
  logic                 start_req_w;
  logic                 busy_w;
  logic                 done_w;
  logic                 tick_w;
  logic                 run_w;
  logic                 loop_w;
  logic [DIV_W-1:0]     div_w;
  logic [XFER_BITS-1:0] tx_w;
  logic [XFER_BITS-1:0] rx_w;

  assign run_w = busy_w && !done_w;

  spim_regs #(
    .NUM_CS(NUM_CS), .DIV_W(DIV_W), .XFER_BITS(XFER_BITS)
  ) u_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_valid(bus_valid), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .done(done_w), .rx_bits(rx_w),
    .start(start_w), .start_req(start_req_w), .busy(busy_w),
    .loop_en(loop_w), .div(div_w), .cs(cs_o), .tx_byte(tx_w)
  );

  spim_baud #(.DIV_W(DIV_W)) u_baud (
    .clk(clk), .rst_n(rst_n), .run(run_w), .div(div_w), .tick(tick_w)
  );

  spim_shift #(
    .XFER_BITS(XFER_BITS), .CPOL(CPOL), .CPHA(CPHA)
  ) u_shift (
    .clk(clk), .rst_n(rst_n), .start(start_w), .tx_byte(tx_w),
    .tick(tick_w), .loop_en(loop_w), .miso(miso_i),
    .sck(sck_o), .mosi(mosi_o), .fin(done_w), .rx_bits(rx_w)
  );
endmodule

// File: rtl/spim_checker.sv
`timescale 1ns/1ps
module spim_checker #(
  parameter int NUM_CS = 3,
  parameter bit CPOL   = 1'b0,
  parameter bit CPHA   = 1'b0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              start,
  input logic              start_req,
  input logic              done,
  input logic              sck,
  input logic              mosi,
  input logic [NUM_CS-1:0] cs
);
  localparam bit HOLD_LVL = CPHA ? CPOL : !CPOL;

  a_r3_cs_hold: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> $stable(cs));

  a_r5_sck_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> sck == CPOL);

  a_r4_busy_after_go: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy);

  a_r9_rise_needs_go: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start_req));

  a_r5_done_drops_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);

  a_r6_mosi_hold: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) && sck == HOLD_LVL && $past(sck) == HOLD_LVL
      |-> $stable(mosi));
endmodule

bind spi_master_regs spim_checker #(
  .NUM_CS(NUM_CS), .CPOL(CPOL), .CPHA(CPHA)
) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy_w), .start(start_w),
  .start_req(start_req_w), .done(done_w), .sck(sck_o), .mosi(mosi_o),
  .cs(cs_o)
);

// File: tb/sim_spi_master_regs.sv
`timescale 1ns/1ps
module sim_spi_master_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0;
  logic        bus_we = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        sck_o, mosi_o;
  logic        miso_i = 1'b0;
  logic [2:0]  cs_o;

  always #4 clk = ~clk;

  spi_master_regs u0 (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .sck_o(sck_o), .mosi_o(mosi_o), .miso_i(miso_i), .cs_o(cs_o)
  );

  int n_chk = 0;
  int n_err = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // behavioural reference: exchange window in clock counts
  int       m_start = -100000;
  int       m_end   = -100000;
  int       m_ds    = 0;
  int       m_d     = 0;
  logic [2:0] m_cs  = 3'b111;
  logic     m_loop  = 1'b0;

  function automatic bit m_busy(input int c);
    return (c >= m_start) && (c <= m_end);
  endfunction

  function automatic bit m_sck(input int c);
    if (!m_busy(c)) return 1'b0;
    return (((c - m_start) / (m_ds + 1)) % 2) == 1;
  endfunction

  task automatic check(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // per-clock comparison of the pins against the model (R3, R5)
  always @(negedge clk) begin
    if (rst_n) begin
      check(sck_o === m_sck(cyc), "R5 sck timing", {31'b0, sck_o}, {31'b0, m_sck(cyc)});
      check(cs_o === m_cs, "R3 chip selects", {29'b0, cs_o}, {29'b0, m_cs});
    end
  end

  // slave on the bus: samples on rising, drives on falling
  logic [7:0] s_tx = '0;
  logic [7:0] s_rx = '0;
  int         s_idx = 0;
  always @(posedge sck_o) s_rx = {s_rx[6:0], mosi_o};
  always @(negedge sck_o) begin
    s_idx++;
    if (s_idx < 8) miso_i = s_tx[7 - s_idx];
  end

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    int x;
    x = cyc;
    bus_valid = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    if (a == 2'd0 && !m_busy(x)) begin
      m_cs   = {d[4], d[2], d[0]};
      m_loop = d[3];
      m_d    = int'(d[31:27]);
      if (d[1]) begin
        m_start = x + 1;
        m_ds    = m_d;
        m_end   = m_start + 15 * (m_d + 1);
      end
    end
    @(negedge clk);
    bus_valid = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] v);
    bus_valid = 1'b1; bus_we = 1'b0; bus_addr = a;
    #1;
    v = bus_rdata;
    bus_valid = 1'b0;
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    forever begin
      rd(2'd0, v);
      check(v[1] === m_busy(cyc), "R4 busy flag", {31'b0, v[1]}, {31'b0, m_busy(cyc)});
      if (v[1] !== 1'b1) break;
      @(negedge clk);
    end
  endtask

  task automatic launch(input logic [7:0] tx, input logic [7:0] slave, input logic [31:0] ctrlw);
    wr(2'd1, {24'b0, tx});
    s_tx = slave; s_idx = 0; s_rx = '0; miso_i = slave[7];
    wr(2'd0, ctrlw | 32'h2);
  endtask

  task automatic xfer(input logic [7:0] tx, input logic [7:0] slave,
                      input logic [31:0] ctrlw, input logic [7:0] exp_rx, input string req);
    logic [31:0] v;
    launch(tx, slave, ctrlw);
    wait_idle();
    rd(2'd1, v);
    check(v === {24'b0, exp_rx}, req, v, {24'b0, exp_rx});
    check(s_rx === tx, "R6 bits seen by slave", {24'b0, s_rx}, {24'b0, tx});
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL R5 watchdog actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R2 reset state
    rd(2'd0, v); check(v === 32'h15, "R2 control after reset", v, 32'h15);
    rd(2'd1, v); check(v === 32'h0, "R2 data after reset", v, 32'h0);
    check(cs_o === 3'b111, "R2 chip selects after reset", {29'b0, cs_o}, 32'h7);
    check(sck_o === 1'b0, "R2 sck after reset", {31'b0, sck_o}, 32'h0);
    // R1 unmapped address
    rd(2'd2, v); check(v === 32'h0, "R1 unmapped read", v, 32'h0);
    // R3 chip selects without go
    wr(2'd0, 32'h0);  check(cs_o === 3'b000, "R3 all selects low", {29'b0, cs_o}, 32'h0);
    wr(2'd0, 32'h10); check(cs_o === 3'b100, "R3 select 2 only", {29'b0, cs_o}, 32'h4);
    wr(2'd0, 32'h15);
    // R5 R6 R7 fastest divider
    xfer(8'h3C, 8'hA5, 32'h14, 8'hA5, "R7 received byte D=0");
    rd(2'd0, v); check(v === 32'h14, "R4 go bit not stored", v, 32'h14);
    // divider 3
    xfer(8'h81, 8'h7E, (32'd3 << 27) | 32'h11, 8'h7E, "R7 received byte D=3");
    rd(2'd0, v); check(v === ((32'd3 << 27) | 32'h11), "R10 divider readback", v, (32'd3 << 27) | 32'h11);
    // R8 loopback with a different byte on the pin
    xfer(8'h5A, 8'h0F, (32'd1 << 27) | 32'h1D, 8'h5A, "R8 loopback byte");
    rd(2'd0, v); check(v === ((32'd1 << 27) | 32'h1D), "R10 loopback readback", v, (32'd1 << 27) | 32'h1D);
    // R9 control write mid-exchange
    launch(8'hC3, 8'h96, (32'd2 << 27) | 32'h14);
    repeat (6) @(negedge clk);
    wr(2'd0, 32'hF800_000A);
    wait_idle();
    rd(2'd0, v); check(v === ((32'd2 << 27) | 32'h14), "R9 control unchanged", v, (32'd2 << 27) | 32'h14);
    rd(2'd1, v); check(v === 32'h96, "R9 loopback not enabled", v, 32'h96);
    check(s_rx === 8'hC3, "R9 exchange not restarted", {24'b0, s_rx}, 32'hC3);
    @(negedge clk);
    // largest divider
    xfer(8'hFF, 8'h00, (32'd31 << 27) | 32'h15, 8'h00, "R7 received byte D=31");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule